// File: doc/BRIEF.md
# Arbitration Message Receiver with Host Interrupts

This unit sits behind the bus-side decoder of a distributed arbiter and takes in the arbitration-message words that the decoder hands over, one word per cycle. Each word arrives with a parity bit. Words that pass the parity check are pushed out to an external FIFO through a one-cycle strobe and a registered data bus. The word that opens a message is also latched in an on-chip register, where the host can collect it. This means only one word per message has to be held inside the block.

The host reaches the unit through a small register port. Every access is answered with a single-cycle data acknowledge. The unit drives three outputs to the host:
- a message-received interrupt;
- an error interrupt, backed by a sticky error status register;
- a power-fail pin, raised when the opening word carries a fixed code.

All three are cleared by host writes that set bits to 1. If a new message opens while the previous opening word is still unread, the old word is kept and an overrun error is logged.

Top module: `arb_msg_rx`

## Requirements
- R1: A parity-clean word with `msg_first_i` high is latched in the first-word register, which reads back at address 0. Status bit 2 (unread) is set by the capture and cleared by a read of address 0.
- R2: Each parity-clean valid word, first or not, gives exactly one `fifo_stb_o` pulse one clock after it is presented, with `fifo_data_o` equal to the word.
- R3: Parity is even over the word and its parity bit. A word that fails is dropped: no strobe, no capture, no message interrupt. It sets error status bit 1.
- R4: `msg_irq_o` rises one clock after a first word is accepted. It stays high through reads and clears only when the host writes 1 to status bit 0 (address 1). A new first word in the same cycle as the clear wins.
- R5: The error status at address 2 is sticky and write-1-to-clear, bit by bit. `err_irq_o` is high exactly while any error status bit is set.
- R6: A first word that arrives while the unread flag is set, and with no read of address 0 in the same cycle, sets error status bit 0. The stored first word is kept unchanged.
- R7: A first word equal to `PFAIL_CODE` raises `pfail_o` one clock later, and status bit 1 mirrors it. It stays high until the host writes 1 to status bit 1. A non-first word with that code has no effect on it.
- R8: `host_ack_o` is a one-cycle pulse in the clock after `host_sel_i` is first seen. Writes take effect at that edge, and `host_rdata_o` is valid while the acknowledge is high.
- R9: After reset, every output is low and all registers are clear.
- R10: Address 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | A word is presented this cycle |
| msg_first_i | input | 1 | The presented word opens a message |
| msg_word_i | input | WORD_W | Message word |
| msg_par_i | input | 1 | Even parity bit for the word |
| fifo_stb_o | output | 1 | Push strobe to the external FIFO |
| fifo_data_o | output | WORD_W | Word for the external FIFO |
| msg_irq_o | output | 1 | Message-received interrupt |
| err_irq_o | output | 1 | Error interrupt |
| pfail_o | output | 1 | Power-fail message received |
| host_sel_i | input | 1 | Host access request, held until acknowledge |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 2 | Register address |
| host_wdata_i | input | WORD_W | Write data |
| host_rdata_o | output | WORD_W | Read data, valid with acknowledge |
| host_ack_o | output | 1 | Data acknowledge |

## Verification
A wrong unread flag shows up in two ways. The status read returns the wrong value, and the next opening word either raises a spurious overrun on the error interrupt one clock later or silently overwrites a word the host has not read. A stuck interrupt or power-fail flop is visible on its pin in the cycle after the clearing write acknowledges. A wrong parity or code decode appears one clock after the word as a missing or extra FIFO strobe, or as a wrong pin level. Sweeping every word value as an opening word therefore exposes a decode error at the exact code it corrupts.

// File: rtl/arb_rx_pkg.sv
package arb_rx_pkg;
  typedef enum logic [1:0] {
    ADDR_FIRST = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_ERR   = 2'd2,
    ADDR_RSVD  = 2'd3
  } rx_addr_e;

  localparam int STAT_MSG  = 0;
  localparam int STAT_PF   = 1;
  localparam int STAT_FULL = 2;
  localparam int ERR_OVR   = 0;
  localparam int ERR_PAR   = 1;

  typedef struct packed {
    logic cap;   // first word accepted
    logic ovr;   // first word while unread
    logic perr;  // parity failure
    logic pf;    // power-fail code seen
  } rx_evt_t;
endpackage

// File: rtl/arb_rx_parity.sv
module arb_rx_parity #(
  parameter int W   = 16,
  parameter bit ODD = 1'b0
) (
  input  logic [W-1:0] word_i,
  input  logic         par_i,
  output logic         ok_o
);
  generate
    if (ODD) begin : g_odd
      assign ok_o = ^{word_i, par_i};
    end else begin : g_even
      assign ok_o = ~^{word_i, par_i};
    end
  endgenerate
endmodule

// File: rtl/arb_rx_capture.sv
module arb_rx_capture
  import arb_rx_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [W-1:0] PFAIL_CODE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         first_i,
  input  logic [W-1:0] word_i,
  input  logic         par_ok_i,
  input  logic         rd_first_i,
  output logic [W-1:0] first_o,
  output logic         full_o,
  output rx_evt_t      evt_o,
  output logic         fifo_stb_o,
  output logic [W-1:0] fifo_data_o
);
  logic         good, take, ovr, capture;
  logic [W-1:0] first_q;
  logic         full_q;

  assign good    = valid_i & par_ok_i;
  assign take    = good & first_i;
  assign ovr     = take & full_q & ~rd_first_i;
  assign capture = take & ~ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= '0;
      full_q      <= 1'b0;
      fifo_stb_o  <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_stb_o <= good;
      if (good) fifo_data_o <= word_i;
      if (capture) first_q <= word_i;
      if (capture)         full_q <= 1'b1;
      else if (rd_first_i) full_q <= 1'b0;
    end
  end

  always_comb begin
    evt_o      = '0;
    evt_o.cap  = take;
    evt_o.ovr  = ovr;
    evt_o.perr = valid_i & ~par_ok_i;
    evt_o.pf   = take & (word_i == PFAIL_CODE);
  end

  assign first_o = first_q;
  assign full_o  = full_q;

  // R6
  keep_unread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !rd_first_i |=> $stable(first_q));
  // R2
  stb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_stb_o |-> $past(valid_i) && $past(par_ok_i));
endmodule

// File: rtl/arb_rx_host.sv
module arb_rx_host
  import arb_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] first_i,
  input  logic         full_i,
  input  rx_evt_t      evt_i,
  output logic         rd_first_o,
  output logic [W-1:0] rdata_o,
  output logic         ack_o,
  output logic         msg_irq_o,
  output logic         err_irq_o,
  output logic         pfail_o
);
  logic         acc, wr_stat, wr_err;
  logic         msg_q, pf_q, ovr_q, par_q;
  logic [W-1:0] rd_d;
  logic         unused_wdata;

  assign acc        = sel_i & ~ack_o;
  assign wr_stat    = acc & wr_i & (rx_addr_e'(addr_i) == ADDR_STAT);
  assign wr_err     = acc & wr_i & (rx_addr_e'(addr_i) == ADDR_ERR);
  assign rd_first_o = acc & ~wr_i & (rx_addr_e'(addr_i) == ADDR_FIRST);
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rd_d = '0;
    case (rx_addr_e'(addr_i))
      ADDR_FIRST: rd_d = first_i;
      ADDR_STAT: begin
        rd_d[STAT_MSG]  = msg_q;
        rd_d[STAT_PF]   = pf_q;
        rd_d[STAT_FULL] = full_i;
      end
      ADDR_ERR: begin
        rd_d[ERR_OVR] = ovr_q;
        rd_d[ERR_PAR] = par_q;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
      msg_q   <= 1'b0;
      pf_q    <= 1'b0;
      ovr_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      ack_o <= acc;
      if (acc && !wr_i) rdata_o <= rd_d;
      // set wins over clear
      msg_q <= evt_i.cap  | (msg_q & ~(wr_stat & wdata_i[STAT_MSG]));
      pf_q  <= evt_i.pf   | (pf_q  & ~(wr_stat & wdata_i[STAT_PF]));
      ovr_q <= evt_i.ovr  | (ovr_q & ~(wr_err  & wdata_i[ERR_OVR]));
      par_q <= evt_i.perr | (par_q & ~(wr_err  & wdata_i[ERR_PAR]));
    end
  end

  assign msg_irq_o = msg_q;
  assign pfail_o   = pf_q;
  assign err_irq_o = ovr_q | par_q;

  // R8
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(sel_i));
  // R8
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R7
  pf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_q && !(wr_stat && wdata_i[STAT_PF]) |=> pf_q);
  // R5
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> $past(evt_i.ovr || evt_i.perr));
endmodule

// File: rtl/arb_msg_rx.sv
module arb_msg_rx
  import arb_rx_pkg::*;
#(
  parameter int           WORD_W     = 16,
  parameter bit           ODD_PAR    = 1'b0,
  parameter logic [WORD_W-1:0] PFAIL_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic              msg_first_i,
  input  logic [WORD_W-1:0] msg_word_i,
  input  logic              msg_par_i,
  output logic              fifo_stb_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic              msg_irq_o,
  output logic              err_irq_o,
  output logic              pfail_o,
  input  logic              host_sel_i,
  input  logic              host_wr_i,
  input  logic [1:0]        host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              host_ack_o
);
  logic              par_ok, full, rd_first;
  logic [WORD_W-1:0] first_word;
  rx_evt_t           evt;

  arb_rx_parity #(.W(WORD_W), .ODD(ODD_PAR)) u_par (
    .word_i (msg_word_i),
    .par_i  (msg_par_i),
    .ok_o   (par_ok)
  );

  arb_rx_capture #(.W(WORD_W), .PFAIL_CODE(PFAIL_CODE)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (msg_valid_i),
    .first_i     (msg_first_i),
    .word_i      (msg_word_i),
    .par_ok_i    (par_ok),
    .rd_first_i  (rd_first),
    .first_o     (first_word),
    .full_o      (full),
    .evt_o       (evt),
    .fifo_stb_o  (fifo_stb_o),
    .fifo_data_o (fifo_data_o)
  );

  arb_rx_host #(.W(WORD_W)) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (host_sel_i),
    .wr_i       (host_wr_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .first_i    (first_word),
    .full_i     (full),
    .evt_i      (evt),
    .rd_first_o (rd_first),
    .rdata_o    (host_rdata_o),
    .ack_o      (host_ack_o),
    .msg_irq_o  (msg_irq_o),
    .err_irq_o  (err_irq_o),
    .pfail_o    (pfail_o)
  );

  // R4
  msg_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_irq_o) |-> $past(msg_valid_i && msg_first_i && par_ok));
endmodule

// File: tb/arb_msg_rx_test.sv
module arb_msg_rx_test;
  localparam int W = 8;
  localparam logic [W-1:0] PF = 8'hA5;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         msg_valid = 1'b0, msg_first = 1'b0, msg_par = 1'b0;
  logic [W-1:0] msg_word = '0;
  logic         fifo_stb, msg_irq, err_irq, pfail;
  logic [W-1:0] fifo_data, rdata;
  logic         sel = 1'b0, wr = 1'b0, ack;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  arb_msg_rx #(.WORD_W(W), .ODD_PAR(1'b0), .PFAIL_CODE(PF)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .msg_valid_i(msg_valid), .msg_first_i(msg_first),
    .msg_word_i(msg_word), .msg_par_i(msg_par),
    .fifo_stb_o(fifo_stb), .fifo_data_o(fifo_data),
    .msg_irq_o(msg_irq), .err_irq_o(err_irq), .pfail_o(pfail),
    .host_sel_i(sel), .host_wr_i(wr), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_ack_o(ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit first, input logic [W-1:0] w, input bit bad);
    @(negedge clk);
    msg_valid = 1'b1;
    msg_first = first;
    msg_word  = w;
    msg_par   = bad ? ~(^w) : ^w;
    @(negedge clk);
    msg_valid = 1'b0;
    msg_first = 1'b0;
  endtask

  task automatic host(input bit w, input logic [1:0] a, input logic [W-1:0] d,
                      output int rd);
    int lat;
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 8);
    chk("R8 ack latency", lat, 1);
    rd = int'(rdata);
    sel = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R8 ack single pulse", int'(ack), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9
    chk("R9 reset outputs",
        int'({fifo_stb, msg_irq, err_irq, pfail, ack}), 0);
    host(0, 2'd1, '0, rd); chk("R9 reset status", rd, 0);
    host(0, 2'd2, '0, rd); chk("R9 reset errors", rd, 0);

    for (int i = 0; i < 256; i++) begin
      bit is_pf;
      is_pf = (i == int'(PF));
      send(1'b1, W'(i), 1'b0);
      chk("R2 strobe", int'(fifo_stb), 1);
      chk("R2 fifo data", int'(fifo_data), i);
      chk("R4 msg irq set", int'(msg_irq), 1);
      chk("R7 pfail decode", int'(pfail), int'(is_pf));
      chk("R5 no err", int'(err_irq), 0);
      @(negedge clk);
      chk("R2 strobe one cycle", int'(fifo_stb), 0);
      host(0, 2'd1, '0, rd);
      chk("R1 unread set", rd, 4 + (is_pf ? 2 : 0) + 1);
      host(0, 2'd0, '0, rd); chk("R1 first word", rd, i);
      host(0, 2'd1, '0, rd);
      chk("R1 unread cleared", rd, (is_pf ? 2 : 0) + 1);
      chk("R4 irq held over reads", int'(msg_irq), 1);
      host(1, 2'd1, 8'h01, rd);
      chk("R4 irq cleared", int'(msg_irq), 0);
      chk("R7 pfail kept by msg clear", int'(pfail), int'(is_pf));
      host(1, 2'd1, 8'h02, rd);
      chk("R7 pfail cleared", int'(pfail), 0);
    end

    // R7: code in a non-first word
    send(1'b0, PF, 1'b0);
    chk("R2 strobe non-first", int'(fifo_stb), 1);
    chk("R7 non-first ignored", int'(pfail), 0);
    chk("R4 non-first no irq", int'(msg_irq), 0);
    host(0, 2'd1, '0, rd); chk("R1 non-first no capture", rd, 0);

    // R3 parity failures
    for (int i = 0; i < 256; i += 17) begin
      send(1'b1, W'(i), 1'b1);
      chk("R3 no strobe", int'(fifo_stb), 0);
      chk("R3 no msg irq", int'(msg_irq), 0);
      chk("R5 err irq", int'(err_irq), 1);
      host(0, 2'd2, '0, rd); chk("R3 parity bit", rd, 2);
      host(0, 2'd1, '0, rd); chk("R3 no capture", rd, 0);
      host(1, 2'd2, 8'h02, rd);
      chk("R5 err cleared", int'(err_irq), 0);
    end

    // R6 overrun
    send(1'b1, 8'h11, 1'b0);
    send(1'b1, 8'h22, 1'b0);
    chk("R6 err irq", int'(err_irq), 1);
    host(0, 2'd2, '0, rd); chk("R6 overrun bit", rd, 1);
    host(0, 2'd0, '0, rd); chk("R6 old word kept", rd, 8'h11);
    send(1'b1, 8'h33, 1'b1);
    host(0, 2'd2, '0, rd); chk("R5 both bits", rd, 3);
    host(1, 2'd2, 8'h01, rd);
    host(0, 2'd2, '0, rd); chk("R5 w1c selective", rd, 2);
    chk("R5 irq while bit set", int'(err_irq), 1);
    host(1, 2'd2, 8'h02, rd);
    chk("R5 irq clear", int'(err_irq), 0);

    // R10 reserved address
    host(1, 2'd3, 8'hFF, rd);
    host(0, 2'd3, '0, rd); chk("R10 reads zero", rd, 0);
    host(0, 2'd1, '0, rd); chk("R10 status untouched", rd, 1);
    host(1, 2'd1, 8'h01, rd);
    chk("R4 final clear", int'(msg_irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule